// File: doc/BRIEF.md
# Predicated vector conditional select

This block walks a conditional-select operation across a vector of up to 64 elements, one element per clock. For every element it takes one bit out of a 256-bit condition vector made of 4-bit condition fields, moving forward by one field per element from a widened base index. A set bit chooses the RA operand, where RA register number 0 stands for the literal value zero. A clear bit chooses the RB operand.

A single start pulse latches the whole configuration: vector length, vector flag, predicate mask and enable, base index, condition vector, RA register number, mode and the previous value of the destination mask. The sequencer then presents one element per cycle. The index goes out on the element write port, and the operand read data for that element is expected back on the same cycle. Predication suppresses the write of a masked element and never zeroes it.

In predicate mode no element is written. The selected condition bits are instead packed into a 64-bit mask that starts from the previous destination value. A one-cycle done pulse marks the end of every run.

Top module: `pvsel_core`

## Requirements
- R1: While rst_n is low and after its release with no start, wr_en_o is 0, done_o is 0 and mask_o is all zeros.
- R2: A start accepted at a clock edge leads to element cycles in the following cycles, with wr_idx_o = i in the i-th one (i from 0). With vec_i = 1 the number of elements is vlen_i, limited to 64.
- R3: The condition bit of element i is bit ((base_i + 4*i) mod 256) of cond_i, counted from bit 0 as the LSB. base_i and cond_i are captured at start.
- R4: When the condition bit is 1, wr_data_o is ra_data_i, or zero when the captured ra_num_i is 0. When the condition bit is 0, wr_data_o is rb_data_i. Operand data is taken during the element cycle itself.
- R5: With pred_en_i = 1 captured at start, an element i whose pmask_i bit i is 0 has wr_en_o = 0 during its cycle and leaves mask_o unchanged. With pred_en_i = 0 every element is active.
- R6: With mode_i = 1 (predicate mode), wr_en_o stays 0 and mask_o starts as prior_i. Each active element i then sets mask_o bit i to its condition bit. With mode_i = 0, mask_o equals prior_i from start onward. mask_o holds its value until the next accepted start.
- R7: With vec_i = 0, exactly one element (index 0) is processed, whatever vlen_i is.
- R8: done_o is 1 for exactly the one cycle after the last element cycle, with wr_en_o = 0 in that cycle. With vec_i = 1 and vlen_i = 0, done_o is 1 in the cycle right after the start edge and no element is written.
- R9: A start that arrives during element cycles or during the done cycle is ignored.
- R10: Pulling rst_n low in the middle of a run forces wr_en_o, done_o and mask_o to 0 at once. The block is idle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, acted on only when idle |
| vlen_i | input | 7 | Vector length 0..64 (larger values limited to 64) |
| vec_i | input | 1 | 1 = vector run, 0 = single element |
| pred_en_i | input | 1 | Predication enable |
| pmask_i | input | 64 | Predicate mask, bit i gates element i |
| base_i | input | 8 | Extended condition-bit base index |
| cond_i | input | 256 | Condition vector, 64 fields of 4 bits |
| ra_num_i | input | 5 | RA register number (0 selects literal zero) |
| ra_data_i | input | 64 | RA read data for the current element |
| rb_data_i | input | 64 | RB read data for the current element |
| mode_i | input | 1 | 0 = element writes, 1 = predicate-mask result |
| prior_i | input | 64 | Previous destination mask value |
| wr_en_o | output | 1 | Element write enable |
| wr_idx_o | output | 6 | Current element index (also the read index) |
| wr_data_o | output | 64 | Selected element data |
| mask_o | output | 64 | Packed predicate-mask result |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
A wrong element counter shows on wr_idx_o within the same cycle. It also shows as a done pulse that comes too early or too late, which the bench sees in the cycle right after the expected last element. A wrong condition-bit position or operand choice appears on wr_data_o during the element cycle concerned. A corrupted mask bit shows only when the run ends, so the mask is compared in the done cycle and again after the ignored starts. A start that gets through while busy restarts the index at zero and loads the injected configuration, and the next element cycle or the cycle after done exposes it.

// File: rtl/pvsel_pkg.sv
package pvsel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pvsel_ctrl.sv
module pvsel_ctrl
  import pvsel_pkg::*;
#(
  parameter int ELEMS = 64,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int VL_W  = $clog2(ELEMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             vec_i,
  input  logic [VL_W-1:0]  vlen_i,
  output logic             load_o,
  output logic             run_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_q, last_d;
  logic             idx_en;
  logic [VL_W-1:0]  cnt;

  assign load_o = start_i && (state_q == ST_IDLE);

  always_comb begin
    if (!vec_i)
      cnt = VL_W'(1);
    else if (vlen_i > VL_W'(ELEMS))
      cnt = VL_W'(ELEMS);
    else
      cnt = vlen_i;
    last_d = IDX_W'(cnt - VL_W'(1));
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          idx_d   = '0;
          idx_en  = 1'b1;
          state_d = (cnt == '0) ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        if (idx_q == last_q) begin
          state_d = ST_FIN;
        end else begin
          idx_d  = idx_q + IDX_W'(1);
          idx_en = 1'b1;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q  <= idx_d;
      if (load_o) last_q <= last_d;
    end
  end

  assign run_o  = (state_q == ST_RUN);
  assign done_o = (state_q == ST_FIN);
  assign idx_o  = idx_q;

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && $past(run_o)) |-> (idx_o == $past(idx_o) + IDX_W'(1))); // R2

  AST_RUN_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> (idx_o == '0)); // R2

endmodule

// File: rtl/pvsel_pick.sv
module pvsel_pick #(
  parameter int ELEMS   = 64,
  parameter int FIELD_W = 4,
  parameter int XLEN    = 64,
  parameter int REGN_W  = 5,
  localparam int IDX_W  = $clog2(ELEMS),
  localparam int CVEC_W = ELEMS * FIELD_W,
  localparam int BASE_W = $clog2(CVEC_W)
) (
  input  logic              clk,
  input  logic              load_i,
  input  logic [CVEC_W-1:0] cond_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [REGN_W-1:0] ra_num_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [XLEN-1:0]   ra_data_i,
  input  logic [XLEN-1:0]   rb_data_i,
  output logic              cbit_o,
  output logic              ra_zero_o,
  output logic [XLEN-1:0]   data_o
);

  logic [CVEC_W-1:0] cond_q;
  logic [BASE_W-1:0] base_q;
  logic [REGN_W-1:0] ra_num_q;
  logic [BASE_W-1:0] offset;
  logic [BASE_W-1:0] pos;

  always_ff @(posedge clk) begin
    if (load_i) begin
      cond_q   <= cond_i;
      base_q   <= base_i;
      ra_num_q <= ra_num_i;
    end
  end

  always_comb begin
    offset    = BASE_W'(idx_i) * BASE_W'(FIELD_W);
    pos       = base_q + offset;
    cbit_o    = cond_q[pos];
    ra_zero_o = (ra_num_q == '0);
    if (!cbit_o)
      data_o = rb_data_i;
    else if (ra_zero_o)
      data_o = '0;
    else
      data_o = ra_data_i;
  end

endmodule

// File: rtl/pvsel_mask.sv
module pvsel_mask #(
  parameter int ELEMS = 64,
  localparam int IDX_W = $clog2(ELEMS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             pred_en_i,
  input  logic [ELEMS-1:0] pmask_i,
  input  logic             mode_i,
  input  logic [ELEMS-1:0] prior_i,
  input  logic             run_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cbit_i,
  output logic             active_o,
  output logic             mode_o,
  output logic [ELEMS-1:0] mask_o
);

  logic             pen_q, mode_q, mask_en;
  logic [ELEMS-1:0] pmask_q, mask_q, mask_d;

  assign active_o = !pen_q || pmask_q[idx_i];
  assign mode_o   = mode_q;

  always_comb begin
    mask_en = 1'b0;
    mask_d  = mask_q;
    if (load_i) begin
      mask_en = 1'b1;
      mask_d  = prior_i;
    end else if (run_i && active_o && mode_q) begin
      mask_en        = 1'b1;
      mask_d[idx_i]  = cbit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q   <= 1'b0;
      mode_q  <= 1'b0;
      pmask_q <= '0;
      mask_q  <= '0;
    end else begin
      if (load_i) begin
        pen_q   <= pred_en_i;
        mode_q  <= mode_i;
        pmask_q <= pmask_i;
      end
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

  AST_NORMAL_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !mode_q) |=> $stable(mask_q)); // R6

  AST_SKIP_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !active_o) |=> $stable(mask_q)); // R5

endmodule

// File: rtl/pvsel_core.sv
module pvsel_core #(
  parameter int ELEMS   = 64,
  parameter int FIELD_W = 4,
  parameter int XLEN    = 64,
  parameter int REGN_W  = 5,
  localparam int IDX_W  = $clog2(ELEMS),
  localparam int VL_W   = $clog2(ELEMS + 1),
  localparam int CVEC_W = ELEMS * FIELD_W,
  localparam int BASE_W = $clog2(CVEC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VL_W-1:0]   vlen_i,
  input  logic              vec_i,
  input  logic              pred_en_i,
  input  logic [ELEMS-1:0]  pmask_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [CVEC_W-1:0] cond_i,
  input  logic [REGN_W-1:0] ra_num_i,
  input  logic [XLEN-1:0]   ra_data_i,
  input  logic [XLEN-1:0]   rb_data_i,
  input  logic              mode_i,
  input  logic [ELEMS-1:0]  prior_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [XLEN-1:0]   wr_data_o,
  output logic [ELEMS-1:0]  mask_o,
  output logic              done_o
);

  logic             load, run, cbit, ra_zero, active, mode_q;
  logic [IDX_W-1:0] idx;

  pvsel_ctrl #(.ELEMS(ELEMS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vec_i(vec_i),
    .vlen_i(vlen_i), .load_o(load), .run_o(run), .done_o(done_o),
    .idx_o(idx)
  );

  pvsel_pick #(.ELEMS(ELEMS), .FIELD_W(FIELD_W), .XLEN(XLEN),
               .REGN_W(REGN_W)) u_pick (
    .clk(clk), .load_i(load), .cond_i(cond_i), .base_i(base_i),
    .ra_num_i(ra_num_i), .idx_i(idx), .ra_data_i(ra_data_i),
    .rb_data_i(rb_data_i), .cbit_o(cbit), .ra_zero_o(ra_zero),
    .data_o(wr_data_o)
  );

  pvsel_mask #(.ELEMS(ELEMS)) u_mask (
    .clk(clk), .rst_n(rst_n), .load_i(load), .pred_en_i(pred_en_i),
    .pmask_i(pmask_i), .mode_i(mode_i), .prior_i(prior_i), .run_i(run),
    .idx_i(idx), .cbit_i(cbit), .active_o(active), .mode_o(mode_q),
    .mask_o(mask_o)
  );

  assign wr_en_o  = run && active && !mode_q;
  assign wr_idx_o = idx;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_NO_WR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_en_o); // R8

  AST_RA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && cbit && ra_zero) |-> (wr_data_o == '0)); // R4

  AST_MASK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> $stable(mask_o)); // R9

endmodule

// File: tb/pvsel_core_test.sv
`timescale 1ns/1ps
module pvsel_core_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [6:0]   vlen_i;
  logic         vec_i, pred_en_i, mode_i;
  logic [63:0]  pmask_i, prior_i, ra_data_i, rb_data_i;
  logic [7:0]   base_i;
  logic [255:0] cond_i;
  logic [4:0]   ra_num_i;
  logic         wr_en_o, done_o;
  logic [5:0]   wr_idx_o;
  logic [63:0]  wr_data_o, mask_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pvsel_core uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vlen_i(vlen_i),
    .vec_i(vec_i), .pred_en_i(pred_en_i), .pmask_i(pmask_i),
    .base_i(base_i), .cond_i(cond_i), .ra_num_i(ra_num_i),
    .ra_data_i(ra_data_i), .rb_data_i(rb_data_i), .mode_i(mode_i),
    .prior_i(prior_i), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
    .wr_data_o(wr_data_o), .mask_o(mask_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [255:0] r256();
    return {r64(), r64(), r64(), r64()};
  endfunction

  function automatic int elem_count(input bit vec, input logic [6:0] vl);
    if (!vec) return 1;
    if (vl > 7'd64) return 64;
    return int'(vl);
  endfunction

  function automatic bit cond_bit(input logic [255:0] cv, input logic [7:0] b,
                                  input int i);
    logic [7:0] p;
    p = b + 8'(4 * i);
    return cv[p];
  endfunction

  task automatic scramble();
    vlen_i = 7'd5; vec_i = 1'b1; pred_en_i = 1'b0; mode_i = 1'b0;
    pmask_i = '0; base_i = 8'($urandom); cond_i = r256();
    ra_num_i = 5'd3; prior_i = r64();
  endtask

  // caller is at a negative edge
  task automatic do_run(input bit vec, input logic [6:0] vl, input bit pen,
                        input logic [63:0] pm, input logic [7:0] b,
                        input logic [255:0] cv, input logic [4:0] ran,
                        input bit md, input logic [63:0] prior, input bit inj);
    int n;
    logic [63:0] emask, a, bb, edata;
    bit act, cb, ewr;
    vec_i = vec; vlen_i = vl; pred_en_i = pen; pmask_i = pm; base_i = b;
    cond_i = cv; ra_num_i = ran; mode_i = md; prior_i = prior;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    n = elem_count(vec, vl);
    emask = prior;
    for (int i = 0; i < n; i++) begin
      a = r64(); bb = r64();
      ra_data_i = a; rb_data_i = bb;
      if (inj && i == 1) begin start_i = 1'b1; scramble(); end
      else start_i = 1'b0;
      #1;
      act = !pen || pm[i];
      cb  = cond_bit(cv, b, i);
      ewr = act && !md;
      chk("R5 wr_en", {63'd0, wr_en_o}, {63'd0, ewr});
      if (ewr) begin
        chk("R2 idx", {58'd0, wr_idx_o}, 64'(i));
        edata = cb ? ((ran == 5'd0) ? 64'd0 : a) : bb;
        chk(cb ? "R4 data ra" : "R3 data rb", wr_data_o, edata);
      end
      if (act && md) emask[i] = cb;
      chk("R8 no early done", {63'd0, done_o}, 64'd0);
      @(negedge clk);
    end
    if (inj) begin start_i = 1'b1; scramble(); end
    #1;
    chk("R8 done", {63'd0, done_o}, 64'd1);
    chk("R8 no wr at done", {63'd0, wr_en_o}, 64'd0);
    chk("R6 mask", mask_o, emask);
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk("R9 idle done", {63'd0, done_o}, 64'd0);
    chk("R9 idle wr", {63'd0, wr_en_o}, 64'd0);
    chk("R6 mask hold", mask_o, emask);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start_i = 1'b0; vlen_i = '0; vec_i = 1'b0;
    pred_en_i = 1'b0; pmask_i = '0; base_i = '0; cond_i = '0;
    ra_num_i = '0; ra_data_i = '0; rb_data_i = '0; mode_i = 1'b0;
    prior_i = '0;
    #1;
    chk("R1 reset wr", {63'd0, wr_en_o}, 64'd0);
    chk("R1 reset done", {63'd0, done_o}, 64'd0);
    chk("R1 reset mask", mask_o, 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 idle wr", {63'd0, wr_en_o}, 64'd0);
    chk("R1 idle done", {63'd0, done_o}, 64'd0);
    @(negedge clk);

    // directed corners
    do_run(1, 7'd0, 0, '0, 8'd0, r256(), 5'd7, 0, r64(), 0);          // R8 empty
    do_run(0, 7'd40, 0, '0, 8'd9, r256(), 5'd7, 0, r64(), 0);         // R7 scalar
    do_run(0, 7'd0, 0, '0, 8'd2, r256(), 5'd7, 1, r64(), 0);          // R7 scalar VL 0
    do_run(1, 7'd70, 0, '0, 8'd1, r256(), 5'd4, 0, r64(), 1);         // R2 clamp, R9
    do_run(1, 7'd64, 0, '0, 8'd253, r256(), 5'd0, 0, r64(), 1);       // R3 wrap, R4 zero
    do_run(1, 7'd33, 1, '0, 8'd5, r256(), 5'd2, 0, r64(), 0);         // R5 all masked
    do_run(1, 7'd64, 1, r64(), 8'd0, r256(), 5'd1, 1, r64(), 1);      // R6 predicate
    do_run(1, 7'd64, 0, '0, 8'd3, {64{4'b1000}}, 5'd0, 1, '0, 0);     // R6 all set

    // R10 reset mid-run
    vec_i = 1'b1; vlen_i = 7'd20; pred_en_i = 1'b0; mode_i = 1'b0;
    cond_i = r256(); prior_i = r64(); start_i = 1'b1;
    @(posedge clk); @(negedge clk); start_i = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk("R10 running", {63'd0, wr_en_o}, 64'd1);
    rst_n = 1'b0;
    #1;
    chk("R10 reset wr", {63'd0, wr_en_o}, 64'd0);
    chk("R10 reset done", {63'd0, done_o}, 64'd0);
    chk("R10 reset mask", mask_o, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R10 idle wr", {63'd0, wr_en_o}, 64'd0);
    chk("R10 idle done", {63'd0, done_o}, 64'd0);
    @(negedge clk);

    // constrained random runs
    for (int k = 0; k < 60; k++) begin
      do_run(($urandom % 8) != 0, 7'($urandom % 72), $urandom % 2,
             r64(), 8'($urandom), r256(), ($urandom % 4 == 0) ? 5'd0 : 5'($urandom),
             $urandom % 2, r64(), $urandom % 2);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule